// File: doc/BRIEF.md
# Word-Serial Montgomery Modular Multiplier

This block forms the Montgomery product Y = A·B·2^(−W·G) mod N for operands made of G words of W bits. The three operands and the single-word reduction constant are written one word at a time into internal register files while the block is idle. A start pulse then runs G outer passes, one for each word of B. Each pass sweeps the words of A and N with one multiplier per stage.

The inner sweep keeps two separate W-bit carries. One belongs to the a·b accumulation and one to the m·n reduction, so neither chain has to wait for the other and no carry ever grows past one word. Stage 1 of a two-stage pipeline forms the partial product word for index i while stage 2 reduces the word from index i−1. The pipeline empties before the top words of the accumulator are folded in at the end of each pass.

After the last pass, one serial pass computes Y−N with a borrow. The difference is kept only when no borrow comes out of the top word. The result waits under a valid/ready handshake until the consumer takes it.

Top module: `wsmont_mul`

## Requirements
- R1: While reset is held and after it is released, busy and resValid are both 0.
- R2: While the block is idle, a cycle with ldValid high writes ldData into word ldIdx of the operand chosen by ldSel: 0 selects A, 1 selects B, 2 selects N, and 3 selects the reduction constant (ldIdx is then unused). Word 0 is the least significant.
- R3: For odd N, A < N, B < N and the constant equal to −N⁻¹ mod 2^W, resWord equals A·B·2^(−W·G) mod N.
- R4: The delivered result is always strictly below N. This includes the all-ones modulus with the largest operands, where the extra subtraction is needed.
- R5: resValid first rises G·G+3·G+1 clock cycles after the edge that accepted start. busy is high from the cycle after that edge up to the cycle before resValid rises.
- R6: A start pulse has no effect while busy or while a result is waiting. The run in progress keeps its timing and its value.
- R7: ldValid has no effect while busy or while a result is waiting. A later run with no reload uses the operands loaded before.
- R8: While resValid is high and resReady is low, resValid stays high and resWord does not change. A cycle with resReady high returns the block to idle on the next cycle.
- R9: A zero operand gives a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ldValid | input | 1 | Operand word write strobe |
| ldSel | input | 2 | Target: 0 A, 1 B, 2 N, 3 constant |
| ldIdx | input | $clog2(G) | Word index within the operand |
| ldData | input | W | Word value |
| start | input | 1 | Begin a multiplication |
| busy | output | 1 | Computation in progress |
| resValid | output | 1 | Result available |
| resReady | input | 1 | Consumer takes the result |
| resWord | output | G·W | Result, word 0 in the low bits |

## Verification
The all-ones modulus with operands of N−1 forces the final subtraction. A design that drops the subtraction, or takes the wrong borrow, returns a value at or above N or one that is off by N. Random odd moduli, a tiny modulus with empty upper words, and zero operands exercise the split carries. A carry chain that is misrouted between the two stages, or a wrong pipeline index, corrupts the words in a way that depends on the data, and the result check against the wide-integer model catches it. Start pulses and word writes are injected in the middle of a run and while a result waits. A block that restarts or takes those writes breaks the per-clock busy/valid model, changes the result, or changes a later run made without reload. A held result under a low resReady must keep its value: a design that overwrites it or lets it go early fails the stability check.

// File: rtl/mont_pkg.sv
package mont_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HEAD,
    ST_INNER,
    ST_DRAIN,
    ST_TAIL,
    ST_FINAL,
    ST_DONE
  } monState_t;

  // strobes from the sequencer into the datapath
  typedef struct packed {
    logic ldOpen;   // operand registers writable
    logic clearY;   // zero the accumulator
    logic head;     // word 0 of stage 1 plus quotient digit
    logic s1En;     // stage 1, product accumulation
    logic s2En;     // stage 2, reduction accumulation
    logic tail;     // fold the carries into the top words
    logic subEn;    // serial trial subtraction
    logic subLast;  // last word of the subtraction
    logic done;     // result is presented
  } monStrobe_t;

endpackage

// File: rtl/mont_ctrl.sv
module mont_ctrl
  import mont_pkg::*;
#(
  parameter int G = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic                      resReady,
  output logic                      busy,
  output logic                      resValid,
  output monStrobe_t                strb,
  output logic [$clog2(G)-1:0]      s1Idx,
  output logic [$clog2(G)-1:0]      s2Idx,
  output logic [$clog2(G)-1:0]      bIdx,
  output logic [$clog2(G+1)-1:0]    subIdx
);

  localparam int AW  = $clog2(G);
  localparam int IW  = $clog2(G + 1);
  localparam int LAT = G * G + 3 * G + 1;
  localparam logic [IW-1:0] LAST_I = IW'(G - 1);
  localparam logic [IW-1:0] TOP_I  = IW'(G);
  localparam logic [AW-1:0] LAST_J = AW'(G - 1);

  monState_t state;
  logic [IW-1:0] iCnt;
  logic [AW-1:0] jCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      iCnt  <= '0;
      jCnt  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          state <= ST_HEAD;
          jCnt  <= '0;
        end
        ST_HEAD: begin
          state <= ST_INNER;
          iCnt  <= IW'(1);
        end
        ST_INNER: begin
          if (iCnt == LAST_I) state <= ST_DRAIN;
          else                iCnt  <= iCnt + IW'(1);
        end
        ST_DRAIN: state <= ST_TAIL;
        ST_TAIL: begin
          if (jCnt == LAST_J) begin
            state <= ST_FINAL;
            iCnt  <= '0;
          end else begin
            state <= ST_HEAD;
            jCnt  <= jCnt + AW'(1);
          end
        end
        ST_FINAL: begin
          if (iCnt == TOP_I) state <= ST_DONE;
          else               iCnt  <= iCnt + IW'(1);
        end
        ST_DONE: if (resReady) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb         = '0;
    strb.ldOpen  = (state == ST_IDLE);
    strb.clearY  = (state == ST_IDLE) && start;
    strb.head    = (state == ST_HEAD);
    strb.s1En    = (state == ST_INNER);
    strb.s2En    = (state == ST_INNER) || (state == ST_DRAIN);
    strb.tail    = (state == ST_TAIL);
    strb.subEn   = (state == ST_FINAL);
    strb.subLast = (state == ST_FINAL) && (iCnt == TOP_I);
    strb.done    = (state == ST_DONE);
  end

  assign s1Idx    = (state == ST_HEAD) ? '0 : iCnt[AW-1:0];
  assign s2Idx    = (state == ST_DRAIN) ? LAST_J : (iCnt[AW-1:0] - AW'(1));
  assign bIdx     = jCnt;
  assign subIdx   = iCnt;
  assign busy     = (state != ST_IDLE) && (state != ST_DONE);
  assign resValid = (state == ST_DONE);

  // cycles since start was accepted, for the latency check
  logic [15:0] latCnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         latCnt <= '0;
    else if (state == ST_IDLE && start) latCnt <= 16'd1;
    else if (busy)                      latCnt <= latCnt + 16'd1;
  end

  // R5: completion lands exactly LAT cycles after acceptance
  a_r5_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resValid) |-> (latCnt == 16'(LAT + 1)));

  // R6: a new pass only starts from idle or from the end of a pass
  a_r6_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && state != ST_TAIL) |=> (state != ST_HEAD));

endmodule

// File: rtl/mont_datapath.sv
module mont_datapath
  import mont_pkg::*;
#(
  parameter int W = 16,
  parameter int G = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  monStrobe_t                strb,
  input  logic [$clog2(G)-1:0]      s1Idx,
  input  logic [$clog2(G)-1:0]      s2Idx,
  input  logic [$clog2(G)-1:0]      bIdx,
  input  logic [$clog2(G+1)-1:0]    subIdx,
  input  logic                      ldValid,
  input  logic [1:0]                ldSel,
  input  logic [$clog2(G)-1:0]      ldIdx,
  input  logic [W-1:0]              ldData,
  output logic [G*W-1:0]            resWord
);

  localparam int AW = $clog2(G);
  localparam int IW = $clog2(G + 1);
  localparam int DW = 2 * W;
  localparam logic [IW-1:0] TOP_I = IW'(G);

  logic [W-1:0] aReg [G];
  logic [W-1:0] bReg [G];
  logic [W-1:0] nReg [G];
  logic [W-1:0] dReg [G];
  logic [W-1:0] yReg [G+1];
  logic [W-1:0] n0p, mReg, tPipe, c1Reg, c2Reg;
  logic         borrowReg, useDiff;

  // stage 1: product word plus accumulator word plus product carry
  logic [W-1:0]  bWord, c1In;
  logic [DW-1:0] s1Sum;
  logic [W-1:0]  mNext;
  assign bWord = bReg[bIdx];
  assign c1In  = strb.head ? '0 : c1Reg;
  assign s1Sum = DW'(yReg[IW'(s1Idx)]) + DW'(c1In)
               + DW'(aReg[s1Idx]) * DW'(bWord);
  assign mNext = s1Sum[W-1:0] * n0p;

  // stage 2: reduction word plus stage 1 result plus reduction carry
  logic [DW-1:0] s2Sum;
  assign s2Sum = DW'(tPipe) + DW'(c2Reg) + DW'(mReg) * DW'(nReg[s2Idx]);

  // end of pass: fold both carries into the top accumulator word
  logic [DW-1:0] tailSum;
  assign tailSum = DW'(c1Reg) + DW'(c2Reg) + DW'(yReg[G]);

  // serial trial subtraction Y - N, N padded with a zero top word
  logic [W-1:0] subN;
  logic         borrowIn;
  logic [W:0]   subDiff;
  assign subN     = (subIdx == TOP_I) ? '0 : nReg[subIdx[AW-1:0]];
  assign borrowIn = (subIdx == '0) ? 1'b0 : borrowReg;
  assign subDiff  = {1'b0, yReg[subIdx]} - {1'b0, subN} - (W+1)'(borrowIn);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < G; k++) begin
        aReg[k] <= '0;
        bReg[k] <= '0;
        nReg[k] <= '0;
        dReg[k] <= '0;
      end
      for (int k = 0; k <= G; k++) yReg[k] <= '0;
      n0p       <= '0;
      mReg      <= '0;
      tPipe     <= '0;
      c1Reg     <= '0;
      c2Reg     <= '0;
      borrowReg <= 1'b0;
      useDiff   <= 1'b0;
    end else begin
      if (strb.ldOpen && ldValid) begin
        unique case (ldSel)
          2'd0: aReg[ldIdx] <= ldData;
          2'd1: bReg[ldIdx] <= ldData;
          2'd2: nReg[ldIdx] <= ldData;
          default: n0p <= ldData;
        endcase
      end
      if (strb.clearY) begin
        for (int k = 0; k <= G; k++) yReg[k] <= '0;
      end
      if (strb.head) begin
        c1Reg <= s1Sum[DW-1:W];
        tPipe <= s1Sum[W-1:0];
        mReg  <= mNext;
        c2Reg <= '0;
      end
      if (strb.s1En) begin
        c1Reg <= s1Sum[DW-1:W];
        tPipe <= s1Sum[W-1:0];
      end
      if (strb.s2En) begin
        c2Reg <= s2Sum[DW-1:W];
        if (s2Idx != '0) yReg[IW'(s2Idx) - IW'(1)] <= s2Sum[W-1:0];
      end
      if (strb.tail) begin
        yReg[G-1] <= tailSum[W-1:0];
        yReg[G]   <= tailSum[DW-1:W];
      end
      if (strb.subEn) begin
        borrowReg <= subDiff[W];
        if (strb.subLast) useDiff <= !subDiff[W];
        else              dReg[subIdx[AW-1:0]] <= subDiff[W-1:0];
      end
    end
  end

  logic [G*W-1:0] aFlat, bFlat, nFlat;
  for (genvar k = 0; k < G; k++) begin : g_flat
    assign resWord[k*W +: W] = useDiff ? dReg[k] : yReg[k];
    assign aFlat[k*W +: W]   = aReg[k];
    assign bFlat[k*W +: W]   = bReg[k];
    assign nFlat[k*W +: W]   = nReg[k];
  end

  // R3: with operands below N the accumulator stays below 2N after each pass
  a_r3_acc_bound: assert property (@(posedge clk) disable iff (!rst_n)
    strb.tail |=> (yReg[G] <= W'(1)));

  // R4: presented result is fully reduced
  a_r4_below_n: assert property (@(posedge clk) disable iff (!rst_n)
    strb.done |-> (resWord < nFlat));

  // R7: operand registers frozen outside idle
  a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.ldOpen |=> ($stable(aFlat) && $stable(bFlat) && $stable(nFlat)));

endmodule

// File: rtl/wsmont_mul.sv
module wsmont_mul
  import mont_pkg::*;
#(
  parameter int W = 16,
  parameter int G = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ldValid,
  input  logic [1:0]             ldSel,
  input  logic [$clog2(G)-1:0]   ldIdx,
  input  logic [W-1:0]           ldData,
  input  logic                   start,
  output logic                   busy,
  output logic                   resValid,
  input  logic                   resReady,
  output logic [G*W-1:0]         resWord
);

  localparam int AW = $clog2(G);
  localparam int IW = $clog2(G + 1);

  monStrobe_t    strb;
  logic [AW-1:0] s1Idx, s2Idx, bIdx;
  logic [IW-1:0] subIdx;

  mont_ctrl #(.G(G)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .resReady (resReady),
    .busy     (busy),
    .resValid (resValid),
    .strb     (strb),
    .s1Idx    (s1Idx),
    .s2Idx    (s2Idx),
    .bIdx     (bIdx),
    .subIdx   (subIdx)
  );

  mont_datapath #(.W(W), .G(G)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strb    (strb),
    .s1Idx   (s1Idx),
    .s2Idx   (s2Idx),
    .bIdx    (bIdx),
    .subIdx  (subIdx),
    .ldValid (ldValid),
    .ldSel   (ldSel),
    .ldIdx   (ldIdx),
    .ldData  (ldData),
    .resWord (resWord)
  );

  // R8: a waiting result is held unchanged until taken
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (resValid && !resReady) |=> (resValid && $stable(resWord)));

endmodule

// File: tb/wsmont_mul_tb.sv
module wsmont_mul_tb;
  localparam int W  = 16;
  localparam int G  = 8;
  localparam int AW = $clog2(G);
  localparam int NB = G * W;
  localparam int L  = G * G + 3 * G + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ldValid = 1'b0;
  logic [1:0] ldSel = '0;
  logic [AW-1:0] ldIdx = '0;
  logic [W-1:0] ldData = '0;
  logic start = 1'b0;
  logic resReady = 1'b0;
  logic busy, resValid;
  logic [NB-1:0] resWord;

  int checks = 0;
  int errs = 0;

  always #4 clk = ~clk;

  wsmont_mul #(.W(W), .G(G)) u_dut (
    .clk(clk), .rst_n(rst_n), .ldValid(ldValid), .ldSel(ldSel), .ldIdx(ldIdx),
    .ldData(ldData), .start(start), .busy(busy), .resValid(resValid),
    .resReady(resReady), .resWord(resWord)
  );

  task automatic check(input bit ok, input string what,
                       input logic [NB-1:0] act, input logic [NB-1:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // per-clock model of the handshake timeline (R5 R6 R8)
  int mLeft = 0;
  bit mValid = 1'b0;
  always @(posedge clk) begin
    if (!rst_n) begin
      mLeft  = 0;
      mValid = 1'b0;
    end else if (mLeft > 0) begin
      if (mLeft == 1) mValid = 1'b1;
      mLeft--;
    end else if (mValid) begin
      if (resReady) mValid = 1'b0;
    end else if (start) begin
      mLeft = L;
    end
  end

  always @(negedge clk) begin
    check(busy == (mLeft > 0), "R1 R5 R6 busy per clock", NB'(busy), NB'(mLeft > 0));
    check(resValid == mValid, "R1 R5 R8 resValid per clock", NB'(resValid), NB'(mValid));
  end

  function automatic logic [NB-1:0] refMont(input logic [NB-1:0] a, b, n);
    logic [2*NB+1:0] x;
    x = (2*NB+2)'(a) * (2*NB+2)'(b);
    for (int k = 0; k < NB; k++) begin
      if (x[0]) x = x + (2*NB+2)'(n);
      x = x >> 1;
    end
    while (x >= (2*NB+2)'(n)) x = x - (2*NB+2)'(n);
    return x[NB-1:0];
  endfunction

  function automatic logic [W-1:0] negInv(input logic [W-1:0] n0);
    logic [31:0] inv, nn;
    nn = 32'(n0);
    inv = nn;
    for (int k = 0; k < 5; k++) inv = inv * (32'd2 - nn * inv);
    inv = 32'd0 - inv;
    return inv[W-1:0];
  endfunction

  function automatic logic [NB-1:0] randWide();
    logic [NB-1:0] r;
    for (int k = 0; k < NB / 32; k++) r[k*32 +: 32] = $urandom;
    return r;
  endfunction

  task automatic loadWord(input logic [1:0] sel, input int idx, input logic [W-1:0] d);
    @(negedge clk);
    ldValid = 1'b1; ldSel = sel; ldIdx = AW'(idx); ldData = d;
    @(posedge clk);
    @(negedge clk);
    ldValid = 1'b0;
  endtask

  task automatic loadAll(input logic [NB-1:0] a, b, n);
    for (int k = 0; k < G; k++) begin
      loadWord(2'd0, k, a[k*W +: W]);
      loadWord(2'd1, k, b[k*W +: W]);
      loadWord(2'd2, k, n[k*W +: W]);
    end
    loadWord(2'd3, 0, negInv(n[W-1:0]));
  endtask

  task automatic runOp(input logic [NB-1:0] a, b, n, input int holdCyc,
                       input bit disturb, input string tag);
    logic [NB-1:0] expv, snap;
    int cnt;
    expv = refMont(a, b, n);
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    cnt = 0;
    while (!resValid && cnt < 1000) begin
      if (disturb && cnt == 20) begin
        start = 1'b1; ldValid = 1'b1; ldSel = 2'd0; ldIdx = '0; ldData = ~a[W-1:0];
      end else begin
        start = 1'b0; ldValid = 1'b0;
      end
      @(posedge clk);
      cnt++;
      @(negedge clk);
    end
    start = 1'b0; ldValid = 1'b0;
    check(cnt == L, {tag, " R5 latency"}, NB'(cnt), NB'(L));
    check(resWord == expv, {tag, " R3 result"}, resWord, expv);
    check(resWord < n, {tag, " R4 below modulus"}, resWord, n);
    snap = resWord;
    for (int h = 0; h < holdCyc; h++) begin
      if (disturb && h == 0) begin
        start = 1'b1; ldValid = 1'b1; ldSel = 2'd1; ldIdx = '0; ldData = ~b[W-1:0];
      end else begin
        start = 1'b0; ldValid = 1'b0;
      end
      @(posedge clk);
      @(negedge clk);
      check(resValid && resWord == snap, {tag, " R8 hold"}, resWord, snap);
    end
    start = 1'b0; ldValid = 1'b0;
    resReady = 1'b1;
    @(posedge clk);
    @(negedge clk);
    resReady = 1'b0;
    check(!resValid && !busy, {tag, " R8 release"}, NB'({busy, resValid}), '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL R5 watchdog expired actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [NB-1:0] a, b, n, a2;
    repeat (3) @(negedge clk);
    check(!busy && !resValid, "R1 during reset", NB'({busy, resValid}), '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !resValid, "R1 after reset", NB'({busy, resValid}), '0);

    // all-ones modulus, largest operands: needs the final subtraction
    n = '1;
    a = n - NB'(1);
    b = n - NB'(1);
    loadAll(a, b, n);
    runOp(a, b, n, 3, 1'b0, "R4 max operands");

    for (int k = 0; k < 6; k++) begin
      n = randWide();
      n[0] = 1'b1;
      n[NB-1] = 1'b1;
      a = randWide() % n;
      b = randWide() % n;
      loadAll(a, b, n);
      runOp(a, b, n, k % 3, k == 2, "R3 random");
      if (k == 2) runOp(a, b, n, 1, 1'b0, "R6 R7 rerun without reload");
    end

    // reload a single word of A only
    a2 = a;
    a2[3*W +: W] = 16'hBEEF;
    loadWord(2'd0, 3, 16'hBEEF);
    runOp(a2, b, n, 0, 1'b0, "R2 single word reload");

    // zero operand
    loadAll('0, b, n);
    runOp('0, b, n, 1, 1'b0, "R9 zero operand");

    // tiny modulus, upper words empty
    n = NB'(3);
    loadAll(NB'(2), NB'(1), n);
    runOp(NB'(2), NB'(1), n, 0, 1'b0, "R3 tiny modulus");

    // mid-width modulus
    n = randWide() >> (NB - 70);
    n[0] = 1'b1;
    a = randWide() % n;
    b = randWide() % n;
    loadAll(a, b, n);
    runOp(a, b, n, 2, 1'b1, "R3 R6 R7 short modulus");

    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule